// File: doc/BRIEF.md
# Tagged Inter-Thread FIFO Cell

This block holds a small circular queue of 64-bit words that hardware threads use to hand data to each other. Every access selects a view with a 4-bit code. The raw view reads or patches queue entries without moving them. The tag view exposes the status word. The two queue views push on a write and pop on a read; one of them waits and the other does not. The semaphore views (codes 4 and 5) and every code from 6 up are inert on this cell.

The empty flag (E), the full flag (F) and a free software flag (T) sit in the tag beside the fill count, and software may load them directly. The waiting queue views act on the flags, not on the fill count. When a waiting access hits a set flag, the block answers with a blocked response and records the requester ID in a waiter mask. The next queue access that is not blocked raises a one-cycle wake pulse with that mask, and the mask then clears. Scheduling the threads is left to the surrounding logic.

Each strobe is handled in the cycle it is presented. The tag and the storage update on that clock edge. The response registers (read data, blocked, wake and mask) show the result in the following cycle and return to zero after that.

Top module: `xfc_cell`

## Requirements
- R1: After reset the tag reads E=1, F=0, T=0, fill count 0, queue-mode flag (bit 17) 1 and log2 of DEPTH in bits 31:28. With the default DEPTH=4 the tag word is 0x20020001. The read, block and wake outputs are 0.
- R2: A tag-view read (code 1) returns E at bit 0, F at bit 1, T at bit 16, queue-mode at bit 17, the fill count from bit 18 and log2 DEPTH at bit 28. A tag-view write loads T, E and F from bits 16, 0 and 1. When the new E is 1, the write also clears the fill count.
- R3: A queue-view write (code 2 waiting, 3 non-waiting) that is not blocked clears E. If the fill count is below DEPTH, it stores the data at (output index + fill count) mod DEPTH and increments the count. F is set when the count equals DEPTH. A write to a full queue is dropped.
- R4: A queue-view read that is not blocked clears F. If the count is above zero, it returns the oldest entry, advances the output index mod DEPTH and decrements the count. E is set when the count is zero. A non-waiting read of an empty queue returns 0.
- R5: A waiting read (code 2) while E is 1 returns blocked=1 and read data 0. It still clears F, pops nothing and sets the requester's bit in the waiter mask.
- R6: A waiting write (code 2) while F is 1 returns blocked=1. It stores nothing, still clears E and sets the requester's bit in the waiter mask. The decision uses the F flag, not the fill count.
- R7: A queue access that is not blocked, made while the waiter mask is non-zero, gives wake=1 with wake_mask equal to the whole mask in the next cycle and clears the mask. A blocked access never wakes.
- R8: A raw-view read (code 0) returns the entry at the output index and does not pop it. A raw-view write replaces the newest entry when the count is above zero and is ignored when the count is zero.
- R9: Codes 4, 5 and 6–15 read as 0. Writes with these codes change nothing and cause no wake.
- R10: Read data, blocked and wake appear one cycle after the strobe. In any cycle that does not follow a read, read data is 0. Blocked and wake are 0 in any cycle that does not follow a queue access.
- R11: When rd_i and wr_i are both high, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| view_i | input | 4 | View code of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| req_id_i | input | 3 | Requester ID (clog2 NREQ) |
| rdata_o | output | 64 | Read data, one cycle after the read |
| blocked_o | output | 1 | Access must stall, one cycle after it |
| wake_o | output | 1 | Wake pulse for the recorded waiters |
| wake_mask_o | output | 8 | Requesters to wake (NREQ bits) |

## Verification
The checker tests the following on every cycle:
- the fill count never exceeds DEPTH;
- blocked and wake are never high together, and wake always carries a non-zero mask;
- the outputs stay quiet after idle cycles;
- a tag write with E=1 empties the count;
- the last push sets F and the last pop sets E;
- semaphore-view writes leave the count unchanged.

Some behaviours only the bench's scenarios can show. These are the data order across wrap-around, the raw-view overwrite of the newest entry, flag-driven blocking with a non-full count, the exact wake masks, and read-over-write priority. The bench compares the ports against its behavioural model on every clock.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    // view codes seen on view_i
    localparam logic [3:0] VIEW_RAW     = 4'd0;
    localparam logic [3:0] VIEW_TAG     = 4'd1;
    localparam logic [3:0] VIEW_Q_WAIT  = 4'd2;
    localparam logic [3:0] VIEW_Q_TRY   = 4'd3;

    // tag word layout
    localparam int TAG_E_BIT     = 0;
    localparam int TAG_F_BIT     = 1;
    localparam int TAG_T_BIT     = 16;
    localparam int TAG_MODE_BIT  = 17;
    localparam int TAG_FILL_LSB  = 18;
    localparam int TAG_DEPTH_LSB = 28;
    localparam int TAG_DEPTH_W   = 4;

    typedef enum logic [3:0] {
        OP_IDLE,
        OP_RAW_RD,
        OP_RAW_WR,
        OP_TAG_RD,
        OP_TAG_WR,
        OP_Q_RD,
        OP_Q_WR,
        OP_NULL_RD,
        OP_NULL_WR
    } op_e;

endpackage

// File: rtl/xfc_decode.sv
module xfc_decode
    import xfc_pkg::*;
(
    input  logic [3:0] view_i,
    input  logic       rd_i,
    input  logic       wr_i,
    output op_e        op_o,
    output logic       wait_o
);

    always_comb begin
        op_o   = OP_IDLE;
        wait_o = 1'b0;
        if (rd_i || wr_i) begin
            unique case (view_i)
                VIEW_RAW:    op_o = rd_i ? OP_RAW_RD : OP_RAW_WR;
                VIEW_TAG:    op_o = rd_i ? OP_TAG_RD : OP_TAG_WR;
                VIEW_Q_WAIT: begin
                    op_o   = rd_i ? OP_Q_RD : OP_Q_WR;
                    wait_o = 1'b1;
                end
                VIEW_Q_TRY:  op_o = rd_i ? OP_Q_RD : OP_Q_WR;
                default:     op_o = rd_i ? OP_NULL_RD : OP_NULL_WR;
            endcase
        end
    end

endmodule

// File: rtl/xfc_ring.sv
module xfc_ring #(
    parameter int DEPTH = 4,
    parameter int DW    = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we_i && waddr_i == AW'(g)) begin
                slot_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = slot_q[raddr_i];

endmodule

// File: rtl/xfc_waitmask.sv
module xfc_waitmask #(
    parameter int NREQ = 8,
    localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [IDW-1:0]  set_id_i,
    input  logic            clr_i,
    output logic [NREQ-1:0] mask_o
);

    for (genvar g = 0; g < NREQ; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[g] <= 1'b0;
            end else if (clr_i) begin
                mask_o[g] <= 1'b0;
            end else if (set_i && set_id_i == IDW'(g)) begin
                mask_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xfc_cell.sv
module xfc_cell
    import xfc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int NREQ  = 8,
    parameter int DW    = 64,
    localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      view_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [IDW-1:0]  req_id_i,
    output logic [DW-1:0]   rdata_o,
    output logic            blocked_o,
    output logic            wake_o,
    output logic [NREQ-1:0] wake_mask_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    // tag state
    logic [PW-1:0] fill_q, fill_d;
    logic [AW-1:0] out_q, out_d;
    logic          flag_e_q, flag_e_d;
    logic          flag_f_q, flag_f_d;
    logic          flag_t_q, flag_t_d;

    // decode
    op_e  op;
    logic is_wait;

    // storage and waiters
    logic          ring_we;
    logic [AW-1:0] ring_waddr;
    logic [DW-1:0] ring_rdata;
    logic          wait_set, wait_clr;
    logic [NREQ-1:0] waiters;

    // response next values
    logic [DW-1:0] rsp_data_d;
    logic          rsp_blk_d;
    logic          rsp_wake_d;
    logic [DW-1:0] tag_word;

    xfc_decode u_decode (
        .view_i (view_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .op_o   (op),
        .wait_o (is_wait)
    );

    xfc_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ring_we),
        .waddr_i (ring_waddr),
        .wdata_i (wdata_i),
        .raddr_i (out_q),
        .rdata_o (ring_rdata)
    );

    xfc_waitmask #(.NREQ(NREQ)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (wait_set),
        .set_id_i (req_id_i),
        .clr_i    (wait_clr),
        .mask_o   (waiters)
    );

    always_comb begin
        tag_word                                = '0;
        tag_word[TAG_E_BIT]                     = flag_e_q;
        tag_word[TAG_F_BIT]                     = flag_f_q;
        tag_word[TAG_T_BIT]                     = flag_t_q;
        tag_word[TAG_MODE_BIT]                  = 1'b1;
        tag_word[TAG_FILL_LSB +: PW]            = fill_q;
        tag_word[TAG_DEPTH_LSB +: TAG_DEPTH_W]  = TAG_DEPTH_W'(AW);
    end

    // next-state logic for the tag, storage and waiters
    always_comb begin
        fill_d     = fill_q;
        out_d      = out_q;
        flag_e_d   = flag_e_q;
        flag_f_d   = flag_f_q;
        flag_t_d   = flag_t_q;
        ring_we    = 1'b0;
        ring_waddr = out_q;
        wait_set   = 1'b0;
        wait_clr   = 1'b0;
        rsp_data_d = '0;
        rsp_blk_d  = 1'b0;
        rsp_wake_d = 1'b0;

        unique case (op)
            OP_RAW_RD: rsp_data_d = ring_rdata;
            OP_RAW_WR: begin
                if (fill_q != '0) begin
                    ring_we    = 1'b1;
                    ring_waddr = out_q + fill_q[AW-1:0] - AW'(1);
                end
            end
            OP_TAG_RD: rsp_data_d = tag_word;
            OP_TAG_WR: begin
                flag_t_d = wdata_i[TAG_T_BIT];
                flag_e_d = wdata_i[TAG_E_BIT];
                flag_f_d = wdata_i[TAG_F_BIT];
                if (wdata_i[TAG_E_BIT]) begin
                    fill_d = '0;
                end
            end
            OP_Q_RD: begin
                flag_f_d = 1'b0;
                if (is_wait && flag_e_q) begin
                    rsp_blk_d = 1'b1;
                    wait_set  = 1'b1;
                end else begin
                    if (waiters != '0) begin
                        rsp_wake_d = 1'b1;
                        wait_clr   = 1'b1;
                    end
                    if (fill_q != '0) begin
                        rsp_data_d = ring_rdata;
                        out_d      = out_q + AW'(1);
                        fill_d     = fill_q - PW'(1);
                    end
                    if (fill_d == '0) begin
                        flag_e_d = 1'b1;
                    end
                end
            end
            OP_Q_WR: begin
                flag_e_d = 1'b0;
                if (is_wait && flag_f_q) begin
                    rsp_blk_d = 1'b1;
                    wait_set  = 1'b1;
                end else begin
                    if (waiters != '0) begin
                        rsp_wake_d = 1'b1;
                        wait_clr   = 1'b1;
                    end
                    if (fill_q < FULL_CNT) begin
                        ring_we    = 1'b1;
                        ring_waddr = out_q + fill_q[AW-1:0];
                        fill_d     = fill_q + PW'(1);
                    end
                    if (fill_d == FULL_CNT) begin
                        flag_f_d = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // tag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q   <= '0;
            out_q    <= '0;
            flag_e_q <= 1'b1;
            flag_f_q <= 1'b0;
            flag_t_q <= 1'b0;
        end else begin
            fill_q   <= fill_d;
            out_q    <= out_d;
            flag_e_q <= flag_e_d;
            flag_f_q <= flag_f_d;
            flag_t_q <= flag_t_d;
        end
    end

    // response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o     <= '0;
            blocked_o   <= 1'b0;
            wake_o      <= 1'b0;
            wake_mask_o <= '0;
        end else begin
            rdata_o     <= rsp_data_d;
            blocked_o   <= rsp_blk_d;
            wake_o      <= rsp_wake_d;
            wake_mask_o <= rsp_wake_d ? waiters : '0;
        end
    end

endmodule

// File: rtl/xfc_cell_chk.sv
module xfc_cell_chk #(
    parameter int DEPTH = 4,
    parameter int NREQ  = 8,
    parameter int DW    = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = AW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      view_i,
    input logic            rd_i,
    input logic            wr_i,
    input logic [DW-1:0]   wdata_i,
    input logic [DW-1:0]   rdata_o,
    input logic            blocked_o,
    input logic            wake_o,
    input logic [NREQ-1:0] wake_mask_o,
    input logic [PW-1:0]   fill_q,
    input logic            flag_e_q,
    input logic            flag_f_q
);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= PW'(DEPTH));

    p_last_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && view_i == 4'd3 && fill_q == PW'(DEPTH - 1))
        |=> (flag_f_q && fill_q == PW'(DEPTH)));

    p_last_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && view_i == 4'd3 && fill_q == PW'(1))
        |=> (flag_e_q && fill_q == '0));

    p_tag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && view_i == 4'd1 && wdata_i[0]) |=> (fill_q == '0));

    p_block_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_o |-> !wake_o);

    p_wake_has_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (wake_mask_o != '0));

    p_quiet_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (rdata_o == '0));

    p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !wr_i) |=> (!blocked_o && !wake_o));

    p_sema_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && (view_i == 4'd4 || view_i == 4'd5))
        |=> ($stable(fill_q) && !wake_o && !blocked_o));

endmodule

bind xfc_cell xfc_cell_chk #(.DEPTH(DEPTH), .NREQ(NREQ), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .view_i      (view_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .blocked_o   (blocked_o),
    .wake_o      (wake_o),
    .wake_mask_o (wake_mask_o),
    .fill_q      (fill_q),
    .flag_e_q    (flag_e_q),
    .flag_f_q    (flag_f_q)
);

// File: tb/xfc_cell_test.sv
`timescale 1ns/1ps
module xfc_cell_test;

    localparam int D = 4;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  view = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [2:0]  rid = '0;
    logic [63:0] rdata;
    logic        blocked, wake;
    logic [7:0]  wmask;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit running = 1'b0;

    always #2 clk = ~clk;

    xfc_cell #(.DEPTH(D), .NREQ(N), .DW(64)) uut (
        .clk(clk), .rst_n(rst_n), .view_i(view), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .req_id_i(rid), .rdata_o(rdata),
        .blocked_o(blocked), .wake_o(wake), .wake_mask_o(wmask)
    );

    // behavioural reference model
    logic [63:0] m_mem [D];
    int          m_out, m_ptr;
    bit          m_e, m_f, m_t;
    logic [7:0]  m_wait;
    logic [63:0] x_rd;
    bit          x_blk, x_wake;
    logic [7:0]  x_mask;

    function automatic logic [63:0] m_tag();
        return (64'(2) << 28) | (64'(m_ptr) << 18) | (64'(1) << 17) |
               (64'(m_t) << 16) | (64'(m_f) << 1) | 64'(m_e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) m_mem[i] = '0;
            m_out = 0; m_ptr = 0; m_e = 1; m_f = 0; m_t = 0; m_wait = '0;
            x_rd = '0; x_blk = 0; x_wake = 0; x_mask = '0;
        end else begin
            x_rd = '0; x_blk = 0; x_wake = 0; x_mask = '0;
            if (rd) begin
                case (view)
                    4'd0: x_rd = m_mem[m_out];
                    4'd1: x_rd = m_tag();
                    4'd2, 4'd3: begin
                        m_f = 0;
                        if (view == 4'd2 && m_e) begin
                            x_blk = 1; m_wait[rid] = 1'b1;
                        end else begin
                            if (m_wait != 0) begin x_wake = 1; x_mask = m_wait; m_wait = '0; end
                            if (m_ptr > 0) begin
                                x_rd = m_mem[m_out]; m_out = (m_out + 1) % D; m_ptr--;
                            end
                            if (m_ptr == 0) m_e = 1;
                        end
                    end
                    default: ;
                endcase
            end else if (wr) begin
                case (view)
                    4'd0: if (m_ptr > 0) m_mem[(m_out + m_ptr - 1) % D] = wdata;
                    4'd1: begin
                        m_t = wdata[16]; m_e = wdata[0]; m_f = wdata[1];
                        if (m_e) m_ptr = 0;
                    end
                    4'd2, 4'd3: begin
                        m_e = 0;
                        if (view == 4'd2 && m_f) begin
                            x_blk = 1; m_wait[rid] = 1'b1;
                        end else begin
                            if (m_wait != 0) begin x_wake = 1; x_mask = m_wait; m_wait = '0; end
                            if (m_ptr < D) begin
                                m_mem[(m_out + m_ptr) % D] = wdata; m_ptr++;
                            end
                            if (m_ptr == D) m_f = 1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (rdata !== x_rd || blocked !== x_blk || wake !== x_wake || wmask !== x_mask) begin
                errors++;
                $display("FAIL %s model: rdata=%h blk=%0b wake=%0b mask=%h expected rdata=%h blk=%0b wake=%0b mask=%h",
                         cur_req, rdata, blocked, wake, wmask, x_rd, x_blk, x_wake, x_mask);
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: drive at a falling edge, result visible at the next
    task automatic acc(input bit r, input bit w, input logic [3:0] v,
                       input logic [63:0] d, input logic [2:0] id);
        @(negedge clk);
        rd = r; wr = w; view = v; wdata = d; rid = id;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1 reset rdata", rdata, 64'h0);
        chk("R1 reset flags", {61'd0, blocked, wake, |wmask}, 64'h0);
        rst_n = 1'b1;
        running = 1'b1;

        acc(1, 0, 4'd1, 0, 0); chk("R1 reset tag", rdata, 64'h20020001);

        cur_req = "R10";
        @(negedge clk); chk("R10 idle rdata", rdata, 64'h0);

        cur_req = "R4";
        acc(1, 0, 4'd3, 0, 1); chk("R4 try read empty", rdata, 64'h0);
        chk("R4 try read empty not blocked", {63'd0, blocked}, 64'h0);

        cur_req = "R3";
        for (int i = 0; i < 4; i++) acc(0, 1, 4'd3, 64'hA0 + 64'(i), 1);
        acc(1, 0, 4'd1, 0, 0); chk("R3 full tag", rdata, 64'h20120002);
        acc(0, 1, 4'd3, 64'hBAD, 1);
        acc(1, 0, 4'd1, 0, 0); chk("R3 full write dropped", rdata, 64'h20120002);

        cur_req = "R6";
        acc(0, 1, 4'd2, 64'hEE, 3); chk("R6 waiting write on F", {63'd0, blocked}, 64'h1);

        cur_req = "R8";
        acc(1, 0, 4'd0, 0, 0); chk("R8 raw read oldest", rdata, 64'hA0);
        acc(0, 1, 4'd0, 64'hC3, 0);

        cur_req = "R7";
        acc(1, 0, 4'd3, 0, 0); chk("R7 pop data", rdata, 64'hA0);
        chk("R7 wake mask", {55'd0, wake, wmask}, {55'd0, 1'b1, 8'h08});

        cur_req = "R4";
        acc(1, 0, 4'd2, 0, 0); chk("R4 pop order", rdata, 64'hA1);
        acc(1, 0, 4'd2, 0, 0); chk("R4 pop order", rdata, 64'hA2);
        cur_req = "R8";
        acc(1, 0, 4'd2, 0, 0); chk("R8 raw write replaced newest", rdata, 64'hC3);
        cur_req = "R4";
        acc(1, 0, 4'd1, 0, 0); chk("R4 empty tag", rdata, 64'h20020001);

        cur_req = "R5";
        acc(1, 0, 4'd2, 0, 5); chk("R5 waiting read on E", {63'd0, blocked}, 64'h1);
        chk("R5 blocked data", rdata, 64'h0);

        cur_req = "R9";
        acc(1, 0, 4'd4, 0, 0); chk("R9 sema read", rdata, 64'h0);
        acc(0, 1, 4'd5, 64'h9, 0);
        acc(1, 0, 4'd9, 0, 0); chk("R9 unused view read", rdata, 64'h0);
        acc(1, 0, 4'd1, 0, 0); chk("R9 tag unchanged", rdata, 64'h20020001);

        cur_req = "R8";
        acc(0, 1, 4'd0, 64'hDD, 0);
        acc(1, 0, 4'd0, 0, 0); chk("R8 raw write ignored when empty", rdata, 64'hA0);

        cur_req = "R7";
        acc(0, 1, 4'd3, 64'h11, 0);
        chk("R7 wake by write", {55'd0, wake, wmask}, {55'd0, 1'b1, 8'h20});

        cur_req = "R2";
        acc(0, 1, 4'd1, 64'h10000, 0);
        acc(1, 0, 4'd1, 0, 0); chk("R2 tag load T", rdata, 64'h20070000);
        acc(0, 1, 4'd1, 64'h10003, 0);
        acc(1, 0, 4'd1, 0, 0); chk("R2 tag E clears fill", rdata, 64'h20030003);

        cur_req = "R11";
        acc(1, 1, 4'd3, 64'h77, 0); chk("R11 read wins", rdata, 64'h0);
        acc(1, 0, 4'd1, 0, 0); chk("R11 no push", rdata, 64'h20030001);

        cur_req = "R6";
        acc(0, 1, 4'd1, 64'h2, 0);
        acc(0, 1, 4'd2, 64'h44, 2); chk("R6 flag-driven block", {63'd0, blocked}, 64'h1);
        acc(0, 1, 4'd3, 64'h55, 0);
        chk("R6 waiter woken", {55'd0, wake, wmask}, {55'd0, 1'b1, 8'h04});
        acc(1, 0, 4'd1, 0, 0); chk("R6 tag after push", rdata, 64'h20060002);

        cur_req = "R3";
        for (int k = 0; k < 10; k++) begin
            acc(0, 1, 4'd3, 64'h300 + 64'(k), 0);
            acc(0, 1, 4'd3, 64'h400 + 64'(k), 0);
            acc(1, 0, 4'd3, 0, 0);
            acc(1, 0, 4'd2, 0, 0);
        end
        acc(1, 0, 4'd1, 0, 0);

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule